// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Interrupts

This block controls a port of general-purpose pins from a small word-addressed register bus. For each pin, software chooses one of four pad modes: input with pull-up, push-pull output, open-drain output, or plain input. Each pin has an output data bit. That bit can be written directly under a per-pin write-protect mask, or raised and lowered through write-one set and clear registers.

Pin values pass through a two-flop synchroniser. A second pair of flops can be switched in per pin to filter the input. The result is the sampled value that software reads and that the interrupt logic watches. Each pin's interrupt sense is either an edge or a level. A polarity bit selects which edge or level, and an any-edge bit makes both edges count. Sensed events latch into a raw status bit that stays set until software writes one to clear it. The raw status ANDed with an enable mask forms the masked status, and a single interrupt line is the OR of the masked bits.

The register bus needs no handshake. A write is captured on the clock edge at which `bus_sel` and `bus_we` are both high. Read data is combinational from the address, so every access completes in one cycle and no back-pressure exists. Register word offsets, in units of bytes on `bus_addr`:

- 0x00: pad mode
- 0x04: output write-protect
- 0x08: output data
- 0x0C: sampled input
- 0x10: interrupt enable
- 0x14: raw status
- 0x18: masked status
- 0x1C: status clear
- 0x20: sense type
- 0x24: polarity
- 0x28: any-edge
- 0x2C: filter enable
- 0x30: output set
- 0x34: output clear
- 0x38: drive strength
- 0x3C: slew

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is zero. Every pin is an input with pull-up (`pad_oe`=0x00, `pad_pullup`=0xFF), `irq` is 0, and every readable register reads 0.
- R2: The mode field of pin n sits at bits [2n+1:2n] of offset 0x00. In that field, 0 means pull-up input, 1 means push-pull output (driver enabled), 2 means open-drain (driver enabled only while the output bit is 0, and `pad_opendrain` is 1), and 3 means plain input. `pad_out` always carries the output data bit.
- R3: A direct write to output data (0x08) changes only the bits whose write-protect bit (0x04) is 0.
- R4: Writing 1 to a bit at 0x30 sets that output bit, and writing 1 to a bit at 0x34 clears it. The protect mask does not apply to these writes. Writing 0 to a bit at either offset leaves that bit unchanged.
- R5: Offset 0x0C returns each pin's value two clock edges after it changes at the pin, in any pad mode.
- R6: When a pin's filter bit (0x2C) is 1, that pin's sampled value lags the pin by four clock edges instead of two.
- R7: A sense-type bit (0x20) of 0 selects edge sensing. In that mode a polarity bit (0x24) of 1 selects the rising edge and 0 selects the falling edge, and an any-edge bit (0x28) of 1 makes both edges count. The raw status bit sets one edge after the sampled value changes.
- R8: A sense-type bit of 1 selects level sensing, where polarity 1 means high and polarity 0 means low. On the clock edge that captures the status clear, the status bit goes to 0. If the level is still present, the bit sets again on the next edge.
- R9: Writing 1 to a bit at 0x1C clears that raw status bit, and writing 0 has no effect. An edge event that arrives on the same clock edge as the clear leaves the bit set.
- R10: Masked status (0x18) reads raw status ANDed with the enable mask (0x10). `irq` is 1 exactly when any masked status bit is 1.
- R11: The drive-strength bits (0x38, where 1 selects low current) and the slew bits (0x3C, where 1 selects slow) appear unchanged on `pad_lowdrive` and `pad_slowslew`.
- R12: Write-only offsets (0x1C, 0x30, 0x34) read 0. Writes to the read-only offsets (0x0C, 0x14, 0x18) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 8 | Pad input values |
| pad_out | output | 8 | Value driven to pads |
| pad_oe | output | 8 | Pad driver enable |
| pad_pullup | output | 8 | Pad pull-up enable |
| pad_opendrain | output | 8 | Pad is in open-drain mode |
| pad_lowdrive | output | 8 | 1 = low drive current |
| pad_slowslew | output | 8 | 1 = slow slew rate |
| irq | output | 1 | Combined interrupt |

## Verification
The two functions that can collide in one cycle are a software status clear and a new hardware event on the same pin. The bench changes a pin and then counts clock edges, so that the clear write is captured on exactly the edge where the synchronised edge would set the status bit. It then reads back the raw status and expects the edge to survive the clear. The level-sensed case is provoked the same way. There the bench expects the bit to read 0 directly after the clear edge and 1 one edge later, which shows that the clear wins for that one cycle and the held level re-arms the bit afterwards.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    PM_PULLUP_IN  = 2'd0,
    PM_PUSH_PULL  = 2'd1,
    PM_OPEN_DRAIN = 2'd2,
    PM_PLAIN_IN   = 2'd3
  } pin_mode_e;

  // word index = byte offset / 4
  localparam logic [3:0] W_MODE   = 4'h0;
  localparam logic [3:0] W_WPROT  = 4'h1;
  localparam logic [3:0] W_DOUT   = 4'h2;
  localparam logic [3:0] W_DIN    = 4'h3;
  localparam logic [3:0] W_IEN    = 4'h4;
  localparam logic [3:0] W_RAW    = 4'h5;
  localparam logic [3:0] W_MSK    = 4'h6;
  localparam logic [3:0] W_ICLR   = 4'h7;
  localparam logic [3:0] W_ITYPE  = 4'h8;
  localparam logic [3:0] W_IPOL   = 4'h9;
  localparam logic [3:0] W_IANY   = 4'hA;
  localparam logic [3:0] W_FILT   = 4'hB;
  localparam logic [3:0] W_DSET   = 4'hC;
  localparam logic [3:0] W_DCLR   = 4'hD;
  localparam logic [3:0] W_DRIVE  = 4'hE;
  localparam logic [3:0] W_SLEW   = 4'hF;

endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] filt_en,
  output logic [N_PINS-1:0] sampled
);

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic s1, s2, f1, f2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        f1 <= 1'b0;
        f2 <= 1'b0;
      end else begin
        s1 <= pin_in[p];
        s2 <= s1;
        f1 <= s2;
        f2 <= f1;
      end
    end
    assign sampled[p] = filt_en[p] ? f2 : s2;
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] sampled,
  input  logic [N_PINS-1:0] itype,
  input  logic [N_PINS-1:0] ipol,
  input  logic [N_PINS-1:0] iany,
  input  logic [N_PINS-1:0] clr,
  output logic [N_PINS-1:0] raw
);

  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] rise, fall, edge_hit, level_hit, hit_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sampled;
  end

  assign rise      = sampled & ~prev_q;
  assign fall      = ~sampled & prev_q;
  assign edge_hit  = (iany & (rise | fall)) | (~iany & ((ipol & rise) | (~ipol & fall)));
  assign level_hit = ~(sampled ^ ipol);
  // edges survive a simultaneous clear; levels lose to it for one cycle
  assign hit_keep  = (~itype & edge_hit) | (itype & level_hit & ~clr);

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr) | hit_keep;
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((raw & $past(clr & ~hit_keep)) == '0)); // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~clr) != '0) |=> ((raw & $past(raw & ~clr)) == $past(raw & ~clr))); // R9

endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_dout,
  input  logic                wr_set,
  input  logic                wr_clr,
  input  logic [N_PINS-1:0]   wdata,
  input  logic [N_PINS-1:0]   wprot,
  input  logic [2*N_PINS-1:0] mode,
  output logic [N_PINS-1:0]   dout_q,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pad_pullup,
  output logic [N_PINS-1:0]   pad_opendrain
);

  always_ff @(posedge clk) begin
    if (!rst_n)       dout_q <= '0;
    else if (wr_dout) dout_q <= (dout_q & wprot) | (wdata & ~wprot);
    else if (wr_set)  dout_q <= dout_q | wdata;
    else if (wr_clr)  dout_q <= dout_q & ~wdata;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pad
    pin_mode_e m;
    assign m = pin_mode_e'(mode[2*p+1:2*p]);
    always_comb begin
      pad_oe[p]        = 1'b0;
      pad_pullup[p]    = 1'b0;
      pad_opendrain[p] = 1'b0;
      unique case (m)
        PM_PULLUP_IN:  pad_pullup[p] = 1'b1;
        PM_PUSH_PULL:  pad_oe[p] = 1'b1;
        PM_OPEN_DRAIN: begin
          pad_opendrain[p] = 1'b1;
          pad_oe[p]        = ~dout_q[p];
        end
        default:       ;
      endcase
    end
  end

  assign pad_out = dout_q;

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_opendrain & pad_out) == '0)); // R2

  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> ((dout_q & $past(wprot)) == $past(dout_q & wprot))); // R3

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((dout_q & $past(wdata)) == $past(wdata))); // R4

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_pullup,
  output logic [N_PINS-1:0] pad_opendrain,
  output logic [N_PINS-1:0] pad_lowdrive,
  output logic [N_PINS-1:0] pad_slowslew,
  output logic              irq
);

  localparam int MODE_W = 2 * N_PINS;

  logic [3:0]        word;
  logic              wr;
  logic [N_PINS-1:0] wd;
  logic              unused_bits;

  logic [MODE_W-1:0] mode_q;
  logic [N_PINS-1:0] wprot_q, ien_q, itype_q, ipol_q, iany_q, filt_q, drive_q, slew_q;
  logic [N_PINS-1:0] dout_q, sampled, raw, clr;

  assign word        = bus_addr[5:2];
  assign wr          = bus_sel & bus_we;
  assign wd          = bus_wdata[N_PINS-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      wprot_q <= '0;
      ien_q   <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
      iany_q  <= '0;
      filt_q  <= '0;
      drive_q <= '0;
      slew_q  <= '0;
    end else if (wr) begin
      case (word)
        W_MODE:  mode_q  <= bus_wdata[MODE_W-1:0];
        W_WPROT: wprot_q <= wd;
        W_IEN:   ien_q   <= wd;
        W_ITYPE: itype_q <= wd;
        W_IPOL:  ipol_q  <= wd;
        W_IANY:  iany_q  <= wd;
        W_FILT:  filt_q  <= wd;
        W_DRIVE: drive_q <= wd;
        W_SLEW:  slew_q  <= wd;
        default: ;
      endcase
    end
  end

  assign clr = (wr && word == W_ICLR) ? wd : '0;

  gpio_in_cond #(.N_PINS(N_PINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .filt_en(filt_q), .sampled(sampled)
  );

  gpio_irq_unit #(.N_PINS(N_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sampled(sampled), .itype(itype_q), .ipol(ipol_q),
    .iany(iany_q), .clr(clr), .raw(raw)
  );

  gpio_out_ctl #(.N_PINS(N_PINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_dout(wr && word == W_DOUT), .wr_set(wr && word == W_DSET),
    .wr_clr(wr && word == W_DCLR), .wdata(wd), .wprot(wprot_q), .mode(mode_q),
    .dout_q(dout_q), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pullup(pad_pullup), .pad_opendrain(pad_opendrain)
  );

  assign pad_lowdrive = drive_q;
  assign pad_slowslew = slew_q;
  assign irq          = |(raw & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (word)
        W_MODE:  bus_rdata[MODE_W-1:0] = mode_q;
        W_WPROT: bus_rdata[N_PINS-1:0] = wprot_q;
        W_DOUT:  bus_rdata[N_PINS-1:0] = dout_q;
        W_DIN:   bus_rdata[N_PINS-1:0] = sampled;
        W_IEN:   bus_rdata[N_PINS-1:0] = ien_q;
        W_RAW:   bus_rdata[N_PINS-1:0] = raw;
        W_MSK:   bus_rdata[N_PINS-1:0] = raw & ien_q;
        W_ITYPE: bus_rdata[N_PINS-1:0] = itype_q;
        W_IPOL:  bus_rdata[N_PINS-1:0] = ipol_q;
        W_IANY:  bus_rdata[N_PINS-1:0] = iany_q;
        W_FILT:  bus_rdata[N_PINS-1:0] = filt_q;
        W_DRIVE: bus_rdata[N_PINS-1:0] = drive_q;
        W_SLEW:  bus_rdata[N_PINS-1:0] = slew_q;
        default: ;
      endcase
    end
  end

  AST_IRQ_QUIET_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R10

endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pullup, pad_od, pad_ld, pad_ss;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pad_opendrain(pad_od),
    .pad_lowdrive(pad_ld), .pad_slowslew(pad_ss), .irq(irq)
  );

  // {write, addr, data, expected read}
  localparam int NV = 15;
  localparam logic [70:0] TBL [0:NV-1] = '{
    {1'b1, 6'h04, 32'h0F, 32'h0},
    {1'b1, 6'h08, 32'hFF, 32'h0},
    {1'b0, 6'h08, 32'h00, 32'hF0},
    {1'b1, 6'h30, 32'h03, 32'h0},
    {1'b1, 6'h34, 32'h30, 32'h0},
    {1'b0, 6'h08, 32'h00, 32'hC3},
    {1'b1, 6'h04, 32'h00, 32'h0},
    {1'b1, 6'h08, 32'h5A, 32'h0},
    {1'b0, 6'h08, 32'h00, 32'h5A},
    {1'b1, 6'h30, 32'h00, 32'h0},
    {1'b1, 6'h34, 32'h00, 32'h0},
    {1'b0, 6'h08, 32'h00, 32'h5A},
    {1'b0, 6'h1C, 32'h00, 32'h0},
    {1'b1, 6'h0C, 32'hFF, 32'h0},
    {1'b0, 6'h30, 32'h00, 32'h0}
  };

  function automatic string row_tag(int i);
    if (i == 2 || i == 8) return "R3";
    if (i == 5 || i == 11) return "R4";
    return "R12";
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic run_all();
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk({24'h0, pad_oe}, 32'h00, "R1 oe");
    chk({24'h0, pad_pullup}, 32'hFF, "R1 pullup");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    bus_rd(6'h00, v); chk(v, 32'h0, "R1 mode");
    bus_rd(6'h14, v); chk(v, 32'h0, "R1 raw");

    // register vectors
    for (int i = 0; i < NV; i++) begin
      if (TBL[i][70]) bus_wr(TBL[i][69:64], TBL[i][63:32]);
      else begin
        bus_rd(TBL[i][69:64], v);
        chk(v, TBL[i][31:0], row_tag(i));
      end
    end

    // R2 pad modes, output data is 0x5A
    bus_wr(6'h00, 32'hE4);
    @(negedge clk);
    chk({24'h0, pad_oe}, 32'h06, "R2 oe");
    chk({24'h0, pad_pullup}, 32'hF1, "R2 pullup");
    chk({24'h0, pad_od}, 32'h04, "R2 opendrain");
    chk({24'h0, pad_out}, 32'h5A, "R2 out");
    bus_wr(6'h30, 32'h04);
    @(negedge clk);
    chk({24'h0, pad_oe}, 32'h02, "R2 od released");

    // R11 pass-through
    bus_wr(6'h38, 32'hA5);
    bus_wr(6'h3C, 32'h3C);
    @(negedge clk);
    chk({24'h0, pad_ld}, 32'hA5, "R11 drive");
    chk({24'h0, pad_ss}, 32'h3C, "R11 slew");

    // R5 pin1 is a push-pull output yet input still reads the pin
    bus_wr(6'h2C, 32'h01);
    @(negedge clk); pin_in[1] = 1'b1;
    bus_rd(6'h0C, v); chk(v & 32'h2, 32'h0, "R5 before 2 edges");
    bus_rd(6'h0C, v); chk(v & 32'h2, 32'h2, "R5 after 2 edges");
    // R6 filtered pin0
    @(negedge clk); pin_in[0] = 1'b1;
    bus_rd(6'h0C, v);
    bus_rd(6'h0C, v);
    bus_rd(6'h0C, v); chk(v & 32'h1, 32'h0, "R6 after 3 edges");
    bus_rd(6'h0C, v); chk(v & 32'h1, 32'h1, "R6 after 4 edges");

    // interrupts: pin2 rising edge enabled, pin3 level high, pin4 rising edge
    bus_wr(6'h24, 32'h1C);
    bus_wr(6'h20, 32'h08);
    bus_wr(6'h10, 32'h04);
    bus_wr(6'h1C, 32'hFF);
    bus_rd(6'h14, v); chk(v, 32'h0, "R9 clear all");
    @(negedge clk); pin_in[2] = 1'b1;
    bus_rd(6'h14, v);
    bus_rd(6'h14, v); chk(v & 32'h4, 32'h0, "R7 rise after 2");
    bus_rd(6'h14, v); chk(v & 32'h4, 32'h4, "R7 rise after 3");
    chk({31'h0, irq}, 32'h1, "R10 irq on");
    bus_rd(6'h18, v); chk(v, 32'h04, "R10 masked");
    bus_wr(6'h1C, 32'h04);
    @(negedge clk); pin_in[2] = 1'b0;
    repeat (4) bus_rd(6'h14, v);
    chk(v & 32'h4, 32'h0, "R7 falling ignored");
    chk({31'h0, irq}, 32'h0, "R10 irq off");
    bus_wr(6'h28, 32'h04);
    @(negedge clk); pin_in[2] = 1'b1;
    repeat (4) bus_rd(6'h14, v);
    bus_wr(6'h1C, 32'h04);
    @(negedge clk); pin_in[2] = 1'b0;
    repeat (4) bus_rd(6'h14, v);
    chk(v & 32'h4, 32'h4, "R7 any-edge falling");
    bus_wr(6'h1C, 32'h04);

    // R8 level
    @(negedge clk); pin_in[3] = 1'b1;
    repeat (4) bus_rd(6'h14, v);
    chk(v & 32'h8, 32'h8, "R8 level set");
    chk({31'h0, irq}, 32'h0, "R10 unmasked level");
    bus_wr(6'h1C, 32'h08);
    bus_rd(6'h14, v); chk(v & 32'h8, 32'h0, "R8 cleared");
    bus_rd(6'h14, v); chk(v & 32'h8, 32'h8, "R8 re-asserted");
    bus_wr(6'h10, 32'h0C);
    bus_rd(6'h18, v); chk(v, 32'h08, "R10 masked level");
    chk({31'h0, irq}, 32'h1, "R10 irq level");
    bus_wr(6'h18, 32'h00);
    bus_rd(6'h14, v); chk(v & 32'h8, 32'h8, "R12 raw write ignored");

    // R9 edge on the clear edge survives; plain clear works
    @(negedge clk); pin_in[4] = 1'b1;
    repeat (4) bus_rd(6'h14, v);
    bus_wr(6'h1C, 32'h10);
    bus_rd(6'h14, v); chk(v & 32'h10, 32'h0, "R9 plain clear");
    bus_wr(6'h1C, 32'h00);
    @(negedge clk); pin_in[4] = 1'b0;
    repeat (4) bus_rd(6'h14, v);
    @(negedge clk); pin_in[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    bus_wr(6'h1C, 32'h10);
    bus_rd(6'h14, v); chk(v & 32'h10, 32'h10, "R9 edge beats clear");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule